// File: doc/BRIEF.md
# Masked Level Interrupt Controller

This block collects up to 32 level-sensitive interrupt requests and presents one combined request to an upstream controller. Each source owns one bit in a pending register and one bit in an enable register. A high source line, sampled on a clock edge, marks its pending bit. Software clears a pending bit by writing a 1 to it. The combined output is high while at least one source is both pending and enabled.

Alongside the combined output, the block reports the number of the lowest-numbered source that is both pending and enabled. A separate valid flag says whether that number means anything. The register port is a plain valid/write/address/data interface. Reads return data in the same cycle and change no state.

Top module: `mask_irq_ctrl`

## Requirements
- R1: After reset the pending register and the enable register both read 0, `irqOut` is 0 and `irqIdxValid` is 0.
- R2: A source line that is 1 at a rising clock edge sets its pending bit. This happens whatever the enable bit holds. The pending register is read at offset 0x00, with bit n belonging to source n.
- R3: A write to offset 0x04 loads the whole enable register from `busWdata`. A 1 in bit n enables source n. Reading offset 0x04 returns the stored value.
- R4: A write to offset 0x00 clears each pending bit whose data bit is 1. Pending bits whose data bit is 0 keep their value.
- R5: If a source line is 1 at the same edge that a write-1 clear targets its pending bit, the bit stays 1.
- R6: `irqOut` is 1 exactly when some bit is 1 in both the pending and the enable register. It follows a register change within the same cycle.
- R7: `irqIdx` gives the lowest n with pending bit n and enable bit n both 1, and `irqIdxValid` is then 1. When no such n exists, `irqIdxValid` is 0.
- R8: Reads at any offset other than 0x00 or 0x04 return 0, and so does the bus when `busValid` is 0. Writes at other offsets change neither register. Repeated reads return the same value.
- R9: With all source lines low, writing 0 to the enable register and then all ones to the pending register leaves both registers at 0 and `irqOut` at 0.
- R10: A source that is cleared and then drives its line high again sets its pending bit again at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcIn | input | 32 | Level interrupt request lines, bit n for source n |
| busValid | input | 1 | Register access this cycle |
| busWrite | input | 1 | 1 means write, 0 means read |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the same cycle as the access |
| irqOut | output | 1 | Combined request to the upstream controller |
| irqIdx | output | 5 | Lowest pending and enabled source number |
| irqIdxValid | output | 1 | `irqIdx` is meaningful |

## Verification
A pending bit that is lost or stuck shows up in the cycle after the edge that should have changed it. It appears in the read value at offset 0x00, and it appears on `irqOut` and `irqIdx` once that source is enabled. A wrong decode of the clear write shows up when neighbouring pending bits are read back right after the write. A priority error shows up as a wrong `irqIdx` when several enabled sources are pending together, including sources 0 and 31. Set-over-clear ordering can only be seen when a source is held high across its own clear, so the bench builds exactly that case.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef struct packed {
    logic causeAck;
    logic maskLoad;
    logic rdCause;
    logic rdMask;
  } regStrobe_t;
endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CAUSE_OFS = 'h00,
  parameter logic [ADDR_W-1:0] MASK_OFS = 'h04
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobe_t        strobe
);
  logic hitCause;
  logic hitMask;

  assign hitCause = busValid && (busAddr == CAUSE_OFS);
  assign hitMask  = busValid && (busAddr == MASK_OFS);

  always_comb begin
    strobe.causeAck = hitCause && busWrite;
    strobe.maskLoad = hitMask && busWrite;
    strobe.rdCause  = hitCause && !busWrite;
    strobe.rdMask   = hitMask && !busWrite;
  end

  // R8: at most one register is touched per access
  p_one_target_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.causeAck, strobe.maskLoad, strobe.rdCause, strobe.rdMask}));

  // R8: unaddressed accesses raise no strobe
  p_no_stray_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!busValid) |-> (strobe == '0));
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  regStrobe_t      strobe,
  input  logic [NSRC-1:0] srcIn,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] rdata,
  output logic [NSRC-1:0] reqVec,
  output logic            irqOut
);
  logic [NSRC-1:0] causeQ;
  logic [NSRC-1:0] maskQ;
  logic [NSRC-1:0] clrVec;
  logic [NSRC-1:0] causeNext;

  assign clrVec    = strobe.causeAck ? wdata : '0;
  // the set term comes last, so a live source wins over its own clear
  assign causeNext = (causeQ & ~clrVec) | srcIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      causeQ <= '0;
      maskQ  <= '0;
    end else begin
      causeQ <= causeNext;
      if (strobe.maskLoad) maskQ <= wdata;
    end
  end

  assign reqVec = causeQ & maskQ;
  assign irqOut = |reqVec;

  always_comb begin
    rdata = '0;
    if (strobe.rdCause) rdata = causeQ;
    if (strobe.rdMask)  rdata = maskQ;
  end

  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((causeQ & $past(srcIn)) == $past(srcIn)));

  p_keep_unacked_r4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(causeQ) & ~$past(clrVec)) & ~causeQ) == '0));

  p_mask_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.maskLoad |=> (maskQ == $past(wdata)));

  p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.maskLoad |=> $stable(maskQ));
endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc #(
  parameter int NSRC = 32,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NSRC-1:0]  reqVec,
  output logic [IDX_W-1:0] idx,
  output logic             idxValid
);
  localparam logic [NSRC-1:0] ONE = 1;

  always_comb begin
    idx = '0;
    // scanning downward lets the lowest set bit be the last assignment
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (reqVec[i]) idx = i[IDX_W-1:0];
    end
    idxValid = |reqVec;
  end

  p_idx_lowest_r7: assert property (@(posedge clk) disable iff (!rstN)
    idxValid |-> (reqVec[idx] && ((reqVec & ((ONE << idx) - ONE)) == '0)));

  p_idx_empty_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqVec == '0) |-> !idxValid);
endmodule

// File: rtl/mask_irq_ctrl.sv
module mask_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int ADDR_W = 8,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NSRC-1:0]   srcIn,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [NSRC-1:0]   busWdata,
  output logic [NSRC-1:0]   busRdata,
  output logic              irqOut,
  output logic [IDX_W-1:0]  irqIdx,
  output logic              irqIdxValid
);
  regStrobe_t      strobe;
  logic [NSRC-1:0] reqVec;

  irqc_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .strobe(strobe)
  );

  irqc_datapath #(.NSRC(NSRC)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .srcIn(srcIn),
    .wdata(busWdata), .rdata(busRdata), .reqVec(reqVec), .irqOut(irqOut)
  );

  irqc_prio_enc #(.NSRC(NSRC)) uEnc (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .idx(irqIdx),
    .idxValid(irqIdxValid)
  );

  // R6: the combined output and the encoder's valid flag come from separate logic
  p_out_agrees_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == irqIdxValid);
endmodule

// File: tb/sim_mask_irq_ctrl.sv
module sim_mask_irq_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcIn = '0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;
  logic [4:0]  irqIdx;
  logic        irqIdxValid;

  int nChecks = 0;
  int nFails = 0;
  logic [31:0] rd;

  always #5 clk = ~clk;

  mask_irq_ctrl u0 (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .busValid(busValid),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irqOut(irqOut), .irqIdx(irqIdx),
    .irqIdxValid(irqIdxValid)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    #2 d = busRdata;
    busValid = 1'b0;
  endtask

  task automatic pulseSrc(input logic [31:0] v);
    @(negedge clk); srcIn = v;
    @(negedge clk); srcIn = '0;
  endtask

  task automatic tReset();
    regRead(8'h00, rd); check("R1 cause", rd, 32'h0);
    regRead(8'h04, rd); check("R1 mask", rd, 32'h0);
    check("R1 irqOut", {31'b0, irqOut}, 32'h0);
    check("R1 valid", {31'b0, irqIdxValid}, 32'h0);
  endtask

  task automatic tSetAndMask();
    pulseSrc(32'h0000_0220);
    regRead(8'h00, rd); check("R2 cause set while masked", rd, 32'h0000_0220);
    check("R6 masked output low", {31'b0, irqOut}, 32'h0);
    regWrite(8'h04, 32'h0000_0200);
    regRead(8'h04, rd); check("R3 mask readback", rd, 32'h0000_0200);
    check("R6 output high", {31'b0, irqOut}, 32'h1);
    check("R7 idx 9", {26'b0, irqIdxValid, irqIdx}, {26'b0, 1'b1, 5'd9});
    regWrite(8'h04, 32'hFFFF_FFFF);
    check("R7 idx 5 lowest", {26'b0, irqIdxValid, irqIdx}, {26'b0, 1'b1, 5'd5});
  endtask

  task automatic tAck();
    regWrite(8'h00, 32'h0000_0020);
    regRead(8'h00, rd); check("R4 only bit 5 cleared", rd, 32'h0000_0200);
    check("R7 idx 9 after ack", {26'b0, irqIdxValid, irqIdx}, {26'b0, 1'b1, 5'd9});
  endtask

  task automatic tOtherOffsets();
    regRead(8'h08, rd); check("R8 unmapped read", rd, 32'h0);
    regWrite(8'h08, 32'hFFFF_FFFF);
    regWrite(8'h0C, 32'h0000_0000);
    regRead(8'h04, rd); check("R8 mask untouched", rd, 32'hFFFF_FFFF);
    regRead(8'h00, rd); check("R8 cause untouched", rd, 32'h0000_0200);
    regRead(8'h00, rd); check("R8 repeat read", rd, 32'h0000_0200);
    @(negedge clk); busAddr = 8'h04; #2;
    check("R8 idle bus reads zero", busRdata, 32'h0);
    regWrite(8'h00, 32'h0000_0200);
    check("R6 output low after clear", {31'b0, irqOut}, 32'h0);
    check("R7 valid low", {31'b0, irqIdxValid}, 32'h0);
  endtask

  task automatic tSetWins();
    @(negedge clk); srcIn = 32'h0000_0008;
    regWrite(8'h00, 32'h0000_0008);
    regRead(8'h00, rd); check("R5 set beats clear", rd, 32'h0000_0008);
    @(negedge clk); srcIn = '0;
    regWrite(8'h00, 32'h0000_0008);
    regRead(8'h00, rd); check("R10 cleared once line low", rd, 32'h0);
    pulseSrc(32'h0000_0008);
    regRead(8'h00, rd); check("R10 source sets again", rd, 32'h0000_0008);
    regWrite(8'h00, 32'h0000_0008);
  endtask

  task automatic tPriorityEdges();
    pulseSrc(32'h8000_0000);
    check("R7 idx 31", {26'b0, irqIdxValid, irqIdx}, {26'b0, 1'b1, 5'd31});
    pulseSrc(32'h0000_0001);
    check("R7 idx 0", {26'b0, irqIdxValid, irqIdx}, {26'b0, 1'b1, 5'd0});
    regWrite(8'h04, 32'h8000_0000);
    check("R7 idx 31 with bit 0 masked", {26'b0, irqIdxValid, irqIdx}, {26'b0, 1'b1, 5'd31});
  endtask

  task automatic tQuiesce();
    regWrite(8'h04, 32'h0);
    check("R6 output low after mask clear", {31'b0, irqOut}, 32'h0);
    regWrite(8'h00, 32'hFFFF_FFFF);
    regRead(8'h00, rd); check("R9 cause clear", rd, 32'h0);
    regRead(8'h04, rd); check("R9 mask clear", rd, 32'h0);
    check("R9 irqOut low", {31'b0, irqOut}, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tSetAndMask();
    tAck();
    tOtherOffsets();
    tSetWins();
    tPriorityEdges();
    tQuiesce();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule